// File: doc/BRIEF.md
# Keyed Opcode Permutation Table Generator

This block turns a short secret key into a 256-entry byte permutation. The permutation gives each opcode its encoded byte value. Software or a loader first writes the key bytes through a small write port. It then gives the key length and pulses `start`. The block clears a 256x8 working array to the identity permutation. It then walks an index `i` from 0 to 255, doing one read-modify-write swap per clock, and moves a second index `j` by the current entry plus a key byte. Key bytes are chosen cyclically with `i` modulo the key length.

The finished array serves as the forward table: opcode number `k` is encoded as byte `S[k]`. An instruction decoder needs the opposite direction, so a second array is updated in the same swap steps and always holds the inverse permutation. Both lookups are combinational reads. They return zero until a table has been completed, and they also return zero while a new one is being built.

Top module: `opc_perm_gen`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and both lookup outputs are 0.
- R2: A key write while the block is not busy stores `key_wdata` as key byte number `key_waddr`. A key write while busy is ignored and has no effect on the table being built.
- R3: A start accepted at clock edge E sets `busy` from E on. `busy` stays high for exactly 257 edges: one edge for clearing and 256 edges for the swaps. At edge E+257 `busy` falls and `done` rises. `done` then stays high until the next accepted start.
- R4: The array starts as the identity permutation with `j` = 0. For each `i` from 0 to 255 in order, the block sets `j = (j + S[i] + key[i mod len]) mod 256` and then swaps `S[i]` and `S[j]`. When `done` is high, `op_code` equals `S[op_index]` combinationally.
- R5: The key byte used at step `i` is key byte number `i mod len`, where `len` is the key length captured at start. This holds for lengths 1 through 32.
- R6: When `done` is high, `code_index` equals the `k` for which `S[k] = code_in`, so the two lookups are inverse permutations.
- R7: A start with `key_len` equal to 0 or greater than 32 is rejected. `err` is 1 from the next edge on, `busy` stays 0, and `done` and both tables keep their previous contents. The next accepted start clears `err`.
- R8: While `busy` is high, or before any table has been completed, both lookup outputs are 0.
- R9: A `start` pulse while `busy` is high is ignored: the shuffle in progress and its finish time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Key byte write enable |
| key_waddr | input | 5 | Key byte number to write |
| key_wdata | input | 8 | Key byte value |
| key_len | input | 6 | Key length in bytes, sampled with start |
| start | input | 1 | Request to build a new table |
| busy | output | 1 | Table build in progress |
| done | output | 1 | A complete table is available |
| err | output | 1 | Last start request had an illegal length |
| op_index | input | 8 | Forward lookup address (opcode number) |
| op_code | output | 8 | Encoded byte for `op_index` |
| code_in | input | 8 | Reverse lookup address (encoded byte) |
| code_index | output | 8 | Opcode number for `code_in` |

## Verification
The shuffle is run with a 5-byte key, a 1-byte key and a full 32-byte key. The 1-byte run separates correct modulo indexing from a key pointer that never wraps, and the 32-byte run shows whether the last key byte is ever reached. After each run, all 256 forward and all 256 reverse addresses are swept with opposite orderings, which exposes swap or inverse-update errors at the ends and in the middle of the table. A mid-run key overwrite and a mid-run second start show whether the active build can be disturbed. Starts with lengths 0 and 40, issued after a finished table, show that rejection leaves the table and `done` untouched.

// File: rtl/opc_perm_pkg.sv
package opc_perm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CLEAR,
        PH_SWAP,
        PH_READY
    } perm_phase_e;

endpackage

// File: rtl/opc_perm_keys.sv
module opc_perm_keys #(
    parameter int unsigned KEY_MAX = 32,
    parameter int unsigned SYM_W   = 8,
    localparam int unsigned KEY_AW = $clog2(KEY_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [KEY_AW-1:0] wr_addr,
    input  logic [SYM_W-1:0]  wr_data,
    input  logic [KEY_AW-1:0] rd_addr,
    output logic [SYM_W-1:0]  rd_data
);

    typedef struct packed {
        logic [KEY_MAX-1:0][SYM_W-1:0] bytes;
    } keys_t;

    keys_t keys_d, keys_q;

    always_comb begin
        keys_d = keys_q;
        if (wr_en) begin
            keys_d.bytes[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keys_q <= '0;
        end else begin
            keys_q <= keys_d;
        end
    end

    assign rd_data = keys_q.bytes[rd_addr];

    // R2: a write lands in the addressed byte on the following edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> keys_q.bytes[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/opc_perm_table.sv
module opc_perm_table #(
    parameter int unsigned SYM_W = 8,
    localparam int unsigned TBL_N = 1 << SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_en,
    input  logic             swap_en,
    input  logic [SYM_W-1:0] pos_a,
    input  logic [SYM_W-1:0] pos_b,
    output logic [SYM_W-1:0] val_at_a,
    input  logic [SYM_W-1:0] fwd_addr,
    output logic [SYM_W-1:0] fwd_rdata,
    input  logic [SYM_W-1:0] rev_addr,
    output logic [SYM_W-1:0] rev_rdata
);

    typedef struct packed {
        logic [TBL_N-1:0][SYM_W-1:0] fwd;
        logic [TBL_N-1:0][SYM_W-1:0] inv;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [SYM_W-1:0] va, vb;

    assign va = tbl_q.fwd[pos_a];
    assign vb = tbl_q.fwd[pos_b];

    always_comb begin
        tbl_d = tbl_q;
        if (clear_en) begin
            for (int k = 0; k < TBL_N; k++) begin
                tbl_d.fwd[k] = SYM_W'(k);
                tbl_d.inv[k] = SYM_W'(k);
            end
        end else if (swap_en) begin
            tbl_d.fwd[pos_a] = vb;
            tbl_d.fwd[pos_b] = va;
            tbl_d.inv[va]    = pos_b;
            tbl_d.inv[vb]    = pos_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TBL_N; k++) begin
                tbl_q.fwd[k] <= SYM_W'(k);
                tbl_q.inv[k] <= SYM_W'(k);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign val_at_a  = va;
    assign fwd_rdata = tbl_q.fwd[fwd_addr];
    assign rev_rdata = tbl_q.inv[rev_addr];

    // R6: the inverse array stays consistent with the forward array
    a_r6_inverse_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_q.inv[tbl_q.fwd[pos_a]] == pos_a);

    // R4: after a swap, slot b holds what slot a held before
    a_r4_swap_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && !clear_en) |=> tbl_q.fwd[$past(pos_b)] == $past(va));

endmodule

// File: rtl/opc_perm_ctrl.sv
module opc_perm_ctrl
    import opc_perm_pkg::*;
#(
    parameter int unsigned KEY_MAX = 32,
    parameter int unsigned SYM_W   = 8,
    localparam int unsigned KEY_AW = $clog2(KEY_MAX),
    localparam int unsigned LEN_W  = $clog2(KEY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  key_len,
    input  logic [SYM_W-1:0]  val_at_i,
    input  logic [SYM_W-1:0]  key_byte,
    output logic [KEY_AW-1:0] key_sel,
    output logic [SYM_W-1:0]  idx_i,
    output logic [SYM_W-1:0]  idx_j,
    output logic              clear_en,
    output logic              swap_en,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam logic [SYM_W-1:0] LAST_I  = '1;
    localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(KEY_MAX);

    typedef struct packed {
        perm_phase_e       ph;
        logic [SYM_W-1:0]  i;
        logic [SYM_W-1:0]  j;
        logic [KEY_AW-1:0] kidx;
        logic [LEN_W-1:0]  len;
        logic              done;
        logic              err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [SYM_W-1:0] j_next;
    logic             len_ok;
    logic             kidx_wrap;

    assign j_next    = ctl_q.j + val_at_i + key_byte;
    assign len_ok    = (key_len != '0) && (key_len <= LEN_TOP);
    assign kidx_wrap = (LEN_W'(ctl_q.kidx) == ctl_q.len - 1'b1);

    always_comb begin
        ctl_d    = ctl_q;
        clear_en = 1'b0;
        swap_en  = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE, PH_READY: begin
                if (start) begin
                    if (len_ok) begin
                        ctl_d.ph   = PH_CLEAR;
                        ctl_d.len  = key_len;
                        ctl_d.err  = 1'b0;
                        ctl_d.done = 1'b0;
                    end else begin
                        ctl_d.err  = 1'b1;
                    end
                end
            end
            PH_CLEAR: begin
                clear_en   = 1'b1;
                ctl_d.i    = '0;
                ctl_d.j    = '0;
                ctl_d.kidx = '0;
                ctl_d.ph   = PH_SWAP;
            end
            PH_SWAP: begin
                swap_en    = 1'b1;
                ctl_d.j    = j_next;
                ctl_d.i    = ctl_q.i + 1'b1;
                ctl_d.kidx = kidx_wrap ? '0 : ctl_q.kidx + 1'b1;
                if (ctl_q.i == LAST_I) begin
                    ctl_d.ph   = PH_READY;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign key_sel = ctl_q.kidx;
    assign idx_i   = ctl_q.i;
    assign idx_j   = j_next;
    assign busy    = (ctl_q.ph == PH_CLEAR) || (ctl_q.ph == PH_SWAP);
    assign done    = ctl_q.done;
    assign err     = ctl_q.err;

    // R4: the step index advances by exactly one per swap
    a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_SWAP && ctl_q.i != LAST_I)
            |=> (ctl_q.ph == PH_SWAP) && (ctl_q.i == $past(ctl_q.i) + 1'b1));

    // R5: the key pointer never leaves the captured key length
    a_r5_key_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_SWAP) |-> (LEN_W'(ctl_q.kidx) < ctl_q.len));

    // R9: a start seen mid-shuffle does not restart the clear phase
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_SWAP && ctl_q.i != LAST_I && start) |=> ctl_q.ph == PH_SWAP);

endmodule

// File: rtl/opc_perm_gen.sv
module opc_perm_gen #(
    parameter int unsigned KEY_MAX = 32,
    parameter int unsigned SYM_W   = 8,
    localparam int unsigned KEY_AW = $clog2(KEY_MAX),
    localparam int unsigned LEN_W  = $clog2(KEY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic [KEY_AW-1:0] key_waddr,
    input  logic [SYM_W-1:0]  key_wdata,
    input  logic [LEN_W-1:0]  key_len,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic [SYM_W-1:0]  op_index,
    output logic [SYM_W-1:0]  op_code,
    input  logic [SYM_W-1:0]  code_in,
    output logic [SYM_W-1:0]  code_index
);

    logic [KEY_AW-1:0] key_sel;
    logic [SYM_W-1:0]  key_byte;
    logic [SYM_W-1:0]  idx_i, idx_j, val_at_i;
    logic [SYM_W-1:0]  fwd_raw, rev_raw;
    logic              clear_en, swap_en;

    opc_perm_keys #(.KEY_MAX(KEY_MAX), .SYM_W(SYM_W)) keys_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (key_we && !busy),
        .wr_addr (key_waddr),
        .wr_data (key_wdata),
        .rd_addr (key_sel),
        .rd_data (key_byte)
    );

    opc_perm_ctrl #(.KEY_MAX(KEY_MAX), .SYM_W(SYM_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .key_len  (key_len),
        .val_at_i (val_at_i),
        .key_byte (key_byte),
        .key_sel  (key_sel),
        .idx_i    (idx_i),
        .idx_j    (idx_j),
        .clear_en (clear_en),
        .swap_en  (swap_en),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    opc_perm_table #(.SYM_W(SYM_W)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_en  (clear_en),
        .swap_en   (swap_en),
        .pos_a     (idx_i),
        .pos_b     (idx_j),
        .val_at_a  (val_at_i),
        .fwd_addr  (op_index),
        .fwd_rdata (fwd_raw),
        .rev_addr  (code_in),
        .rev_rdata (rev_raw)
    );

    assign op_code    = done ? fwd_raw : '0;
    assign code_index = done ? rev_raw : '0;

    // R3: a finished table and a build in progress never coexist
    a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R3: done only rises at the end of a build
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R7: an illegal length raises err and does not start a build
    a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (key_len == '0 || key_len > LEN_W'(KEY_MAX)))
            |=> err && !busy && ($stable(done)));

    // R8: lookups stay silent during a build
    a_r8_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (op_code == '0) && (code_index == '0));

endmodule

// File: tb/opc_perm_gen_tb_top.sv
module opc_perm_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_we = 1'b0;
    logic [4:0] key_waddr = '0;
    logic [7:0] key_wdata = '0;
    logic [5:0] key_len = '0;
    logic       start = 1'b0;
    logic       busy, done, err;
    logic [7:0] op_index = '0;
    logic [7:0] op_code;
    logic [7:0] code_in = '0;
    logic [7:0] code_index;

    always #4 clk = ~clk;

    opc_perm_gen dut_i (
        .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_waddr(key_waddr),
        .key_wdata(key_wdata), .key_len(key_len), .start(start),
        .busy(busy), .done(done), .err(err), .op_index(op_index),
        .op_code(op_code), .code_in(code_in), .code_index(code_index)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    // behavioural reference
    int m_key [32];
    int m_tab [256];
    int m_inv [256];
    int m_busy = 0, m_done = 0, m_err = 0, m_cnt = 0;

    task automatic build_ref(input int len);
        int s [256];
        int j = 0;
        for (int i = 0; i < 256; i++) s[i] = i;
        for (int i = 0; i < 256; i++) begin
            int t;
            j = (j + s[i] + m_key[i % len]) % 256;
            t = s[i]; s[i] = s[j]; s[j] = t;
        end
        for (int k = 0; k < 256; k++) begin
            m_tab[k] = s[k];
            m_inv[s[k]] = k;
        end
    endtask

    task automatic cmp(input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    initial begin
        for (int k = 0; k < 32; k++) m_key[k] = 0;
        for (int k = 0; k < 256; k++) begin m_tab[k] = k; m_inv[k] = k; end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
        end else begin
            if (key_we && !m_busy) m_key[key_waddr] = key_wdata;
            if (start && !m_busy) begin
                if (key_len == 0 || key_len > 32) begin
                    m_err = 1;
                end else begin
                    m_err = 0; m_busy = 1; m_done = 0; m_cnt = 257;
                    build_ref(int'(key_len));
                end
            end else if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
            end
        end
        #2;
        cmp("busy", busy, m_busy);
        cmp("done", done, m_done);
        cmp("err", err, m_err);
        cmp("op_code", op_code, m_done ? m_tab[op_index] : 0);
        cmp("code_index", code_index, m_done ? m_inv[code_in] : 0);
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 60000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr_key(input int a, input int v);
        @(negedge clk);
        key_we = 1'b1; key_waddr = 5'(a); key_wdata = 8'(v);
        @(negedge clk);
        key_we = 1'b0;
    endtask

    task automatic go(input int len);
        @(negedge clk);
        key_len = 6'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic sweep();
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            op_index = 8'(k); code_in = 8'(255 - k);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tag = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        tag = "R8";   // no table yet: lookups must read zero
        sweep();

        tag = "R2";
        wr_key(0, 8'h4b); wr_key(1, 8'h65); wr_key(2, 8'h79);
        wr_key(3, 8'h21); wr_key(4, 8'h9c);
        tag = "R3";
        go(5);
        idle(20);
        tag = "R9";   // second start mid-run ignored
        go(3);
        tag = "R2";   // key overwrite mid-run ignored
        wr_key(0, 8'hff);
        tag = "R8";
        sweep();
        tag = "R4";
        idle(10);
        sweep();
        tag = "R6";
        sweep();

        tag = "R7";   // illegal lengths leave the table alone
        go(0);
        sweep();
        go(40);
        sweep();

        tag = "R5";   // one-byte key
        wr_key(0, 8'h07);
        go(1);
        idle(300);
        sweep();

        tag = "R5";   // full-length key
        for (int k = 0; k < 32; k++) wr_key(k, (k * 37 + 11) % 256);
        go(32);
        idle(300);
        sweep();

        tag = "R3";   // rebuild from a ready table
        go(5);
        idle(300);
        tag = "R6";
        sweep();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule